// File: doc/BRIEF.md
# Converter-Clock Capture Phase Selector

This block lives in the converter-clock domain of a digital-to-analog datapath. Input words arrive at the converter rate divided by an interpolation factor of 1, 2, 4 or 8. The block chooses which converter-clock rising edge captures each word. It raises a one-cycle capture strobe on that edge and holds the captured word on its output until the next capture.

In reference-aligned mode, the slower data clock is brought into the converter domain, and each detected rising edge restarts a phase counter at zero. The capture edge is a signed offset of -8 to +7 converter edges from that reference. The offset is reduced modulo the factor, so a negative offset lands in the previous period.

In free-running mode the data clock is not used. The phase counter wraps on its own, and a polarity bit moves the capture edge by half a period. All configuration is sampled only at period boundaries, so a change never splits a period.

Top module: `latch_phase_sel`

## Requirements
- R1: `interp_sel` codes 0, 1, 2, 3 select factors 1, 2, 4, 8. In steady operation `cap_stb` is high for exactly one cycle in every factor-length run of cycles.
- R2: In reference-aligned mode (`ext_mode`=0), let E0 be the converter edge that first samples `data_clk` high after it was sampled low. Capture happens on edge E(3+k), and again every factor cycles after it. Here k is the signed `latch_ofs` value taken modulo the factor.
- R3: `latch_ofs` is two's complement: codes 0 to 7 mean 0 to +7 and codes 8 to 15 mean -8 to -1. A negative value wraps modulo the factor, so -1 at factor 4 gives k=3.
- R4: At factor 1, `cap_stb` is high on every cycle in both modes, whatever the offset and polarity are.
- R5: In free-running mode (`ext_mode`=1), `data_clk` has no effect. The phase counts 0 to factor-1 and wraps, and with `ext_pol`=0 capture happens on phase 0.
- R6: In free-running mode, `ext_pol`=1 moves capture to phase factor/2, which is a shift of 1, 2 or 4 edges at factors 2, 4 and 8.
- R7: In free-running mode, `latch_ofs` has no effect on `cap_stb` or `dout`.
- R8: Factor, mode, polarity and offset are sampled only at a period boundary. A boundary is the edge that leaves the last phase or, in reference-aligned mode, a detected data-clock rise.
- R9: `dout` loads `din` on each edge that raises `cap_stb` and holds its value on every other edge.
- R10: While `rst_n` is low, `cap_stb` and `dout` are 0, and the active setting is factor 1 in reference-aligned mode.
- R11: In reference-aligned mode, a data-clock rise detected partway through a period restarts the phase at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_clk | input | 1 | Slower data clock, asynchronous to clk |
| ext_mode | input | 1 | 0 = reference-aligned, 1 = free-running |
| interp_sel | input | 2 | Interpolation factor code (1x/2x/4x/8x) |
| latch_ofs | input | 4 | Signed capture offset in converter edges |
| ext_pol | input | 1 | Half-period shift in free-running mode |
| din | input | DATA_W | Input data word |
| cap_stb | output | 1 | One-cycle capture strobe |
| dout | output | DATA_W | Captured data word |

## Verification
A corrupted phase counter or a wrong target phase shows at the ports as a strobe on the wrong edge. The error appears within one period of at most eight converter cycles, and `dout` carries a word from the wrong cycle on the same edge. A setting that is loaded outside a boundary moves the strobe inside the period where it was changed. A resync that is missed shows up at the first data-clock rise whose edge does not match the counter's own wrap.

// File: rtl/latch_phase_pkg.sv
package latch_phase_pkg;

  localparam int OFS_W = 4;
  localparam int PH_W  = 3;

  typedef enum logic [1:0] {
    IF_X1 = 2'd0,
    IF_X2 = 2'd1,
    IF_X4 = 2'd2,
    IF_X8 = 2'd3
  } interp_e;

  typedef enum logic {
    MODE_REF = 1'b0,
    MODE_EXT = 1'b1
  } mode_e;

  typedef struct packed {
    interp_e          interp;
    mode_e            mode;
    logic             pol;
    logic [OFS_W-1:0] ofs;
  } cfg_t;

  // Last phase index of a period for a given factor
  function automatic logic [PH_W-1:0] phase_limit(interp_e f);
    logic [PH_W-1:0] r;
    case (f)
      IF_X1:   r = PH_W'(0);
      IF_X2:   r = PH_W'(1);
      IF_X4:   r = PH_W'(3);
      default: r = PH_W'(7);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dclk_sync_edge.sv
module dclk_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_p
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_chain
      if (gi == 0) begin : g_first
        assign sync_d[gi] = async_in;
      end else begin : g_next
        assign sync_d[gi] = sync_q[gi-1];
      end
    end
  endgenerate

  always_comb begin
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_p = sync_q[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |=> !rise_p) else $error("rise pulse longer than one cycle"); // R11

endmodule

// File: rtl/phase_ctr.sv
module phase_ctr
  import latch_phase_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rise_p,
  input  cfg_t                          cfg_in,
  output logic [latch_phase_pkg::PH_W-1:0] cnt_q,
  output logic [latch_phase_pkg::PH_W-1:0] lim,
  output cfg_t                          act_q
);

  logic [PH_W-1:0] cnt_d;
  logic            resync;
  logic            wrap;
  logic            bound;

  always_comb begin
    lim    = phase_limit(act_q.interp);
    resync = (act_q.mode == MODE_REF) && rise_p;
    wrap   = (cnt_q == lim);
    bound  = resync || wrap;
    cnt_d  = bound ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '{interp: IF_X1, mode: MODE_REF, pol: 1'b0, ofs: '0};
    end else if (bound) begin
      act_q <= cfg_in;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim) else $error("phase beyond period"); // R1
  AST_EXT_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.mode == MODE_EXT && cnt_q != lim) |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("free-running phase disturbed"); // R5
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != lim && !rise_p) |=> $stable(act_q)) else $error("setting changed mid-period"); // R8
  AST_RESYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.mode == MODE_REF && rise_p) |=> (cnt_q == '0)) else $error("no resync"); // R11

endmodule

// File: rtl/capture_unit.sv
module capture_unit
  import latch_phase_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [latch_phase_pkg::PH_W-1:0] cnt,
  input  logic [latch_phase_pkg::PH_W-1:0] lim,
  input  cfg_t                             act,
  input  logic [DATA_W-1:0]                din,
  output logic                             cap_stb,
  output logic [DATA_W-1:0]                dout
);

  logic [PH_W:0]     half;
  logic [PH_W-1:0]   target;
  logic              match;
  logic              stb_d;
  logic [DATA_W-1:0] dout_d;

  always_comb begin
    half = ({1'b0, lim} + 1'b1) >> 1;
    if (act.mode == MODE_EXT) begin
      target = act.pol ? half[PH_W-1:0] : '0;
    end else begin
      target = act.ofs[PH_W-1:0] & lim;
    end
    match  = (cnt == target);
    stb_d  = match;
    dout_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_stb <= 1'b0;
    end else begin
      cap_stb <= stb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (match) begin
      dout <= dout_d;
    end
  end

  AST_X1_EVERY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (act.interp == IF_X1) |=> cap_stb) else $error("1x missed an edge"); // R4
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> cap_stb) else $error("dout moved without strobe"); // R9

endmodule

// File: rtl/latch_phase_sel.sv
module latch_phase_sel
  import latch_phase_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              data_clk,
  input  logic                              ext_mode,
  input  logic [1:0]                        interp_sel,
  input  logic [latch_phase_pkg::OFS_W-1:0] latch_ofs,
  input  logic                              ext_pol,
  input  logic [DATA_W-1:0]                 din,
  output logic                              cap_stb,
  output logic [DATA_W-1:0]                 dout
);

  logic            rise_p;
  cfg_t            cfg_in;
  cfg_t            act;
  logic [PH_W-1:0] cnt;
  logic [PH_W-1:0] lim;

  always_comb begin
    cfg_in.interp = interp_e'(interp_sel);
    cfg_in.mode   = mode_e'(ext_mode);
    cfg_in.pol    = ext_pol;
    cfg_in.ofs    = latch_ofs;
  end

  dclk_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (data_clk),
    .rise_p   (rise_p)
  );

  phase_ctr u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_p (rise_p),
    .cfg_in (cfg_in),
    .cnt_q  (cnt),
    .lim    (lim),
    .act_q  (act)
  );

  capture_unit #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt),
    .lim     (lim),
    .act     (act),
    .din     (din),
    .cap_stb (cap_stb),
    .dout    (dout)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dout == '0)) else $error("dout not cleared"); // R10

endmodule

// File: tb/sim_latch_phase_sel.sv
module sim_latch_phase_sel;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          data_clk;
  logic          ext_mode;
  logic [1:0]    interp_sel;
  logic [3:0]    latch_ofs;
  logic          ext_pol;
  logic [DW-1:0] din;
  logic          cap_stb;
  logic [DW-1:0] dout;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int stb_seen = 0;

  // reference model state
  int            m_s1, m_s2, m_s3;
  int            m_cnt;
  int            m_interp, m_mode, m_pol, m_ofs;
  int            m_stb;
  logic [DW-1:0] m_dout;

  // data clock generator
  int  dk_per = 8;
  int  dk_ph  = 0;
  int  dk_rand = 0;

  always #4 clk = ~clk;

  latch_phase_sel #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .data_clk(data_clk), .ext_mode(ext_mode),
    .interp_sel(interp_sel), .latch_ofs(latch_ofs), .ext_pol(ext_pol),
    .din(din), .cap_stb(cap_stb), .dout(dout)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int phase_target(int interp, int mode, int pol, int ofs);
    int fac;
    int sv;
    fac = 1 << interp;
    if (mode == 1) return pol ? fac / 2 : 0;
    sv = (ofs >= 8) ? ofs - 16 : ofs;
    return ((sv % fac) + fac) % fac;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0;
    m_interp = 0; m_mode = 0; m_pol = 0; m_ofs = 0;
    m_stb = 0; m_dout = '0;
  endtask

  // one converter edge of the reference model, using the current inputs
  task automatic model_step();
    int fac;
    int rise;
    int bound;
    int tgt;
    fac   = 1 << m_interp;
    rise  = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
    bound = ((m_mode == 0 && rise == 1) || m_cnt == fac - 1) ? 1 : 0;
    tgt   = phase_target(m_interp, m_mode, m_pol, m_ofs);
    m_stb = (m_cnt == tgt) ? 1 : 0;
    if (m_stb == 1) m_dout = din;
    m_cnt = bound ? 0 : m_cnt + 1;
    if (bound == 1) begin
      m_interp = int'(interp_sel); m_mode = int'(ext_mode);
      m_pol = int'(ext_pol); m_ofs = int'(latch_ofs);
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(data_clk);
  endtask

  task automatic cycle(string tag);
    din = DW'($urandom);
    if (dk_rand != 0) data_clk = 1'($urandom);
    else begin
      data_clk = (dk_ph * 2 < dk_per) ? 1'b1 : 1'b0;
      dk_ph = (dk_ph + 1) % dk_per;
    end
    model_step();
    @(negedge clk);
    if (cap_stb) stb_seen = stb_seen + 1;
    check(tag, "cap_stb", int'(cap_stb), m_stb);
    check(tag, "dout", int'(dout), int'(m_dout));
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  task automatic set_cfg(int mode, int interp, int ofs, int pol);
    ext_mode = 1'(mode); interp_sel = 2'(interp);
    latch_ofs = 4'(ofs); ext_pol = 1'(pol);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; data_clk = 1'b0; din = '0;
    set_cfg(0, 0, 0, 0);
    model_reset();
    repeat (3) @(negedge clk);
    // R10: outputs cleared under reset
    check("R10", "cap_stb", int'(cap_stb), 0);
    check("R10", "dout", int'(dout), 0);
    rst_n = 1'b1;
    check("R10", "cap_stb after release", int'(cap_stb), 0);

    // R4: factor 1 strobes every cycle, any offset
    dk_per = 3;
    set_cfg(0, 0, 5, 0); run("R4", 20);
    set_cfg(1, 0, 9, 1); run("R4", 20);

    // R2 and R1: reference-aligned, positive offsets per factor
    for (int f = 1; f < 4; f++) begin
      for (int o = 0; o < 8; o += 3) begin
        dk_per = 1 << f; dk_ph = 0;
        set_cfg(0, f, o, 0); run("R2", 40);
        stb_seen = 0; run("R1", 64);
        check("R1", "strobe count", stb_seen, 64 >> f);
      end
    end

    // R3: negative offsets wrap into previous period
    for (int f = 1; f < 4; f++) begin
      for (int o = 8; o < 16; o += 2) begin
        dk_per = 1 << f;
        set_cfg(0, f, o, 0); run("R3", 40);
      end
    end
    dk_per = 4; set_cfg(0, 2, 15, 0); run("R3", 40);

    // R11: data clock period differs from the factor, forcing resyncs
    dk_per = 11; dk_ph = 0; set_cfg(0, 3, 2, 0); run("R11", 120);
    dk_per = 5;  set_cfg(0, 2, 13, 0); run("R11", 80);

    // R5 and R7: free-running, data clock random, offset churned
    dk_rand = 1;
    for (int f = 1; f < 4; f++) begin
      set_cfg(1, f, 0, 0); run("R5", 40);
      stb_seen = 0; run("R5", 64);
      check("R5", "strobe count", stb_seen, 64 >> f);
      for (int i = 0; i < 48; i++) begin
        latch_ofs = 4'($urandom);
        cycle("R7");
      end
    end

    // R6: polarity shift in free-running mode
    for (int f = 1; f < 4; f++) begin
      set_cfg(1, f, 3, 1); run("R6", 40);
      set_cfg(1, f, 3, 0); run("R6", 24);
    end
    dk_rand = 0;

    // R8 and R9: random settings changing at random cycles
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 6) == 0)
        set_cfg(int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                int'($urandom_range(0, 15)), int'($urandom_range(0, 1)));
      if ($urandom_range(0, 40) == 0) dk_per = int'($urandom_range(1, 12));
      dk_rand = ($urandom_range(0, 9) == 0) ? 1 : 0;
      cycle((i % 2 == 0) ? "R8" : "R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule